// File: doc/BRIEF.md
# PCI configuration status register

This block holds the 16-bit status word of a PCI bridge's configuration header. Six error flags record events reported by the bridge's master and target engines. Each engine reports an event as a single-cycle strobe. Once a flag is set it stays set until software clears it by writing a one to its bit through the byte-enabled write port. The remaining bits are constants that advertise the bridge's capabilities. The read port always shows the current word, with no added latency.

Each flag is a two-state machine, with states `FLAG_CLEAR` and `FLAG_SET`. The transition CLEAR→SET is taken on a qualified event. The transition SET→CLEAR is taken on a write-one-to-clear with no event in the same cycle. In every other case the flag holds its state.

Two flags are qualified:
- The data-parity flag needs three conditions together: a parity error, the bridge acting as master of that operation, and the parity-response enable level from the command register.
- A master-abort during a special cycle is not recorded.

Top module: `cfg_status_reg`

## Requirements
- R1: After reset the register reads 0x00B0.
- R2: Bit 15 is set by a parity-error strobe, whatever the level of the parity-response enable.
- R3: Bit 8 is set only when the parity-error strobe, the as-master qualifier and the parity-response enable are all high in the same cycle.
- R4: Bit 13 is set by a master-abort strobe unless the special-cycle qualifier is high in that cycle.
- R5: Bit 14 is set by a system-error strobe, bit 12 by a received target-abort strobe, and bit 11 by a signaled target-abort strobe.
- R6: A set flag stays set on every later cycle until it is cleared by a write.
- R7: A write clears each flag whose data bit is 1, provided byte enable bit 1 (covering bits 15:8) is high. A data bit of 0, or byte enable bit 1 low, leaves the flag unchanged.
- R8: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: Bits 7, 5 and 4 always read 1, and bits 10, 9, 6 and 3:0 always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_parity_err | input | 1 | Parity error seen on the bus (strobe) |
| ev_parity_as_master | input | 1 | The bridge was master of the erroneous operation |
| perr_resp_en | input | 1 | Parity-response enable level from the command register |
| ev_serr | input | 1 | Bridge drove a system error (strobe) |
| ev_master_abort | input | 1 | Bridge as master ended a transaction by master-abort (strobe) |
| ev_special_cycle | input | 1 | The aborted transaction was a special cycle |
| ev_tabort_rcvd | input | 1 | Bridge-initiated transaction ended by target-abort (strobe) |
| ev_tabort_sent | input | 1 | Bridge as target issued a target-abort (strobe) |
| wr_en | input | 1 | Configuration write to this register |
| wr_be | input | 2 | Byte enables, bit 1 covers bits 15:8 |
| wr_data | input | 16 | Write data, a 1 clears the matching flag |
| rd_data | output | 16 | Current register value |

## Verification
The bench targets these corner cases:
- A set event coinciding with a clearing write: a design that let the clear win would lose an error that arrived during software's acknowledge.
- A parity error with the enable low, and a parity error with the bridge not master: a design that shared one qualifier between bits 15 and 8 would set too few or too many of them.
- A master-abort flagged as a special cycle: a design that recorded it would set bit 13.
- Writes with the upper byte enable low, and writes of ones into the constant bits: a design that decoded them wrongly would clear flags or disturb the advertised capabilities.

// File: rtl/cfgstat_pkg.sv
`timescale 1ns/1ps
package cfgstat_pkg;
    localparam int REG_W     = 16;
    localparam int BE_W      = REG_W / 8;
    localparam int NUM_FLAGS = 6;

    typedef enum int {
        F_DPE = 0,  // parity error detected
        F_SSE = 1,  // system error signaled
        F_RMA = 2,  // master-abort received
        F_RTA = 3,  // target-abort received
        F_STA = 4,  // target-abort signaled
        F_DPD = 5   // data parity, qualified
    } flag_idx_e;

    localparam int FLAG_POS [NUM_FLAGS] = '{15, 14, 13, 12, 11, 8};

    localparam int POS_FAST_B2B = 7;
    localparam int POS_66MHZ    = 5;
    localparam int POS_CAPLIST  = 4;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_e;
endpackage

// File: rtl/cfgstat_event_qual.sv
`timescale 1ns/1ps
module cfgstat_event_qual
    import cfgstat_pkg::*;
(
    input  logic                 ev_parity_err,
    input  logic                 ev_parity_as_master,
    input  logic                 perr_resp_en,
    input  logic                 ev_serr,
    input  logic                 ev_master_abort,
    input  logic                 ev_special_cycle,
    input  logic                 ev_tabort_rcvd,
    input  logic                 ev_tabort_sent,
    output logic [NUM_FLAGS-1:0] set_vec
);
    always_comb begin
        set_vec        = '0;
        set_vec[F_DPE] = ev_parity_err;
        set_vec[F_SSE] = ev_serr;
        set_vec[F_RMA] = ev_master_abort && !ev_special_cycle;
        set_vec[F_RTA] = ev_tabort_rcvd;
        set_vec[F_STA] = ev_tabort_sent;
        set_vec[F_DPD] = ev_parity_err && ev_parity_as_master && perr_resp_en;
    end
endmodule

// File: rtl/cfgstat_wr_decode.sv
`timescale 1ns/1ps
module cfgstat_wr_decode
    import cfgstat_pkg::*;
(
    input  logic                 wr_en,
    input  logic [BE_W-1:0]      wr_be,
    input  logic [REG_W-1:0]     wr_data,
    output logic [NUM_FLAGS-1:0] clr_vec
);
    logic unused_wr;
    assign unused_wr = ^{wr_data, wr_be};

    generate
        for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_clr
            localparam int POS  = FLAG_POS[i];
            localparam int LANE = POS / 8;
            assign clr_vec[i] = wr_en && wr_be[LANE] && wr_data[POS];
        end
    endgenerate
endmodule

// File: rtl/cfgstat_sticky_flag.sv
`timescale 1ns/1ps
module cfgstat_sticky_flag
    import cfgstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (set_i)           state_d = FLAG_SET;
            FLAG_SET:   if (clr_i && !set_i) state_d = FLAG_CLEAR;
            default:                         state_d = FLAG_CLEAR;
        endcase
    end

    always_comb q_o = (state_q == FLAG_SET);
endmodule

// File: rtl/cfg_status_reg.sv
`timescale 1ns/1ps
module cfg_status_reg
    import cfgstat_pkg::*;
#(
    parameter bit CAP_66MHZ = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_parity_err,
    input  logic              ev_parity_as_master,
    input  logic              perr_resp_en,
    input  logic              ev_serr,
    input  logic              ev_master_abort,
    input  logic              ev_special_cycle,
    input  logic              ev_tabort_rcvd,
    input  logic              ev_tabort_sent,
    input  logic              wr_en,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data
);
    localparam logic [REG_W-1:0] FIXED_BITS =
        (REG_W'(1) << POS_FAST_B2B) |
        (REG_W'(CAP_66MHZ) << POS_66MHZ) |
        (REG_W'(1) << POS_CAPLIST);

    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flag_q;

    cfgstat_event_qual u_qual (
        .ev_parity_err       (ev_parity_err),
        .ev_parity_as_master (ev_parity_as_master),
        .perr_resp_en        (perr_resp_en),
        .ev_serr             (ev_serr),
        .ev_master_abort     (ev_master_abort),
        .ev_special_cycle    (ev_special_cycle),
        .ev_tabort_rcvd      (ev_tabort_rcvd),
        .ev_tabort_sent      (ev_tabort_sent),
        .set_vec             (set_vec)
    );

    cfgstat_wr_decode u_dec (
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .clr_vec (clr_vec)
    );

    generate
        for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
            cfgstat_sticky_flag u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_vec[i]),
                .clr_i (clr_vec[i]),
                .q_o   (flag_q[i])
            );
        end
    endgenerate

    always_comb begin
        rd_data = FIXED_BITS;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            rd_data[FLAG_POS[i]] = flag_q[i];
        end
    end
endmodule

// File: rtl/cfgstat_checker.sv
`timescale 1ns/1ps
module cfgstat_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_parity_err,
    input logic        ev_parity_as_master,
    input logic        perr_resp_en,
    input logic        ev_serr,
    input logic        ev_master_abort,
    input logic        ev_special_cycle,
    input logic        ev_tabort_rcvd,
    input logic        wr_en,
    input logic [1:0]  wr_be,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data
);
    p_dpe_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_parity_err |=> rd_data[15]);

    p_dpd_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[8] && !(ev_parity_err && ev_parity_as_master && perr_resp_en))
        |=> !rd_data[8]);

    p_rma_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_master_abort && !ev_special_cycle) |=> rd_data[13]);

    p_sse_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_serr |=> rd_data[14]);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[15] && !(wr_en && wr_be[1])) |=> rd_data[15]);

    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[1] && wr_data[12] && !ev_tabort_rcvd) |=> !rd_data[12]);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_serr && wr_en && wr_be[1] && wr_data[14]) |=> rd_data[14]);

    p_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & 16'h06FF) == 16'h00B0);
endmodule

bind cfg_status_reg cfgstat_checker u_chk (
    .clk                 (clk),
    .rst_n               (rst_n),
    .ev_parity_err       (ev_parity_err),
    .ev_parity_as_master (ev_parity_as_master),
    .perr_resp_en        (perr_resp_en),
    .ev_serr             (ev_serr),
    .ev_master_abort     (ev_master_abort),
    .ev_special_cycle    (ev_special_cycle),
    .ev_tabort_rcvd      (ev_tabort_rcvd),
    .wr_en               (wr_en),
    .wr_be               (wr_be),
    .wr_data             (wr_data),
    .rd_data             (rd_data)
);

// File: tb/test_cfg_status_reg.sv
`timescale 1ns/1ps
module test_cfg_status_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pe = 0, pm = 0, en = 0, se = 0, ma = 0, sc = 0, tr = 0, ts = 0;
    logic        we = 0;
    logic [1:0]  be = 0;
    logic [15:0] wd = 0;
    logic [15:0] rd;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [15:0] exp_q;

    always #2.5 clk = ~clk;

    cfg_status_reg i_cfg_status_reg (
        .clk(clk), .rst_n(rst_n),
        .ev_parity_err(pe), .ev_parity_as_master(pm), .perr_resp_en(en),
        .ev_serr(se), .ev_master_abort(ma), .ev_special_cycle(sc),
        .ev_tabort_rcvd(tr), .ev_tabort_sent(ts),
        .wr_en(we), .wr_be(be), .wr_data(wd), .rd_data(rd)
    );

    function automatic logic [15:0] model_next(
        input logic [15:0] cur,
        input logic p_e, p_m, p_en, s_e, m_a, s_c, t_r, t_s, w_e,
        input logic [1:0] b_e, input logic [15:0] w_d);
        logic [15:0] f;
        f = cur & 16'hF900;
        if (w_e && b_e[1]) f = f & ~(w_d & 16'hF900);
        if (p_e)                f[15] = 1'b1;
        if (s_e)                f[14] = 1'b1;
        if (m_a && !s_c)        f[13] = 1'b1;
        if (t_r)                f[12] = 1'b1;
        if (t_s)                f[11] = 1'b1;
        if (p_e && p_m && p_en) f[8]  = 1'b1;
        return f | 16'h00B0;
    endfunction

    task automatic chk(input string tag, input logic [15:0] mask);
        checks++;
        if ((rd & mask) !== (exp_q & mask)) begin
            fails++;
            $display("FAIL %s: rd_data&%h actual=%h expected=%h", tag, mask, rd & mask, exp_q & mask);
        end
    endtask

    task automatic chk_bit(input string tag, input logic got, input logic want);
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", tag, got, want);
        end
    endtask

    task automatic check_all();
        chk("R2", 16'h8000);
        chk("R3", 16'h0100);
        chk("R4", 16'h2000);
        chk("R5", 16'h5800);
        chk("R9", 16'h06FF);
    endtask

    // Called at a negative edge: drives one cycle, checks after the edge.
    task automatic apply(input logic p_e, p_m, p_en, s_e, m_a, s_c, t_r, t_s, w_e,
                         input logic [1:0] b_e, input logic [15:0] w_d);
        pe = p_e; pm = p_m; en = p_en; se = s_e; ma = m_a; sc = s_c;
        tr = t_r; ts = t_s; we = w_e; be = b_e; wd = w_d;
        exp_q = model_next(exp_q, p_e, p_m, p_en, s_e, m_a, s_c, t_r, t_s, w_e, b_e, w_d);
        @(posedge clk);
        @(negedge clk);
        pe = 0; pm = 0; en = 0; se = 0; ma = 0; sc = 0; tr = 0; ts = 0;
        we = 0; be = 0; wd = 0;
        check_all();
    endtask

    task automatic idle();
        apply(0,0,0,0,0,0,0,0,0,2'b00,16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1729;
        void'($urandom(seed));
        exp_q = 16'h00B0;
        repeat (3) @(negedge clk);
        chk("R1", 16'hFFFF);             // R1: reset value
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 16'hFFFF);

        // R3/R2: parity error with enable low sets only bit 15
        apply(1,1,0,0,0,0,0,0,0,2'b00,16'h0);
        chk_bit("R3", rd[8], 1'b0);
        chk_bit("R2", rd[15], 1'b1);
        // R3: enable high but not master
        apply(1,0,1,0,0,0,0,0,0,2'b00,16'h0);
        chk_bit("R3", rd[8], 1'b0);
        // R3: all three conditions
        apply(1,1,1,0,0,0,0,0,0,2'b00,16'h0);
        chk_bit("R3", rd[8], 1'b1);
        // R4: special-cycle master-abort ignored
        apply(0,0,0,0,1,1,0,0,0,2'b00,16'h0);
        chk_bit("R4", rd[13], 1'b0);
        apply(0,0,0,0,1,0,0,0,0,2'b00,16'h0);
        chk_bit("R4", rd[13], 1'b1);
        // R5: remaining sources
        apply(0,0,0,1,0,0,1,1,0,2'b00,16'h0);
        chk_bit("R5", rd[14] & rd[12] & rd[11], 1'b1);
        // R6: flags held over idle cycles
        repeat (5) idle();
        chk_bit("R6", rd == 16'hF9B0, 1'b1);
        // R7: writing zeros, and ones with upper byte disabled, changes nothing
        apply(0,0,0,0,0,0,0,0,1,2'b11,16'h0000);
        chk_bit("R7", rd == 16'hF9B0, 1'b1);
        apply(0,0,0,0,0,0,0,0,1,2'b01,16'hFFFF);
        chk_bit("R7", rd == 16'hF9B0, 1'b1);
        // R9: ones to constant/reserved bits do nothing
        apply(0,0,0,0,0,0,0,0,1,2'b01,16'h064F);
        chk_bit("R9", rd[7:0] == 8'hB0 && rd[10:9] == 2'b00, 1'b1);
        // R8: set and clear together on bit 14, clear only bit 12
        apply(0,0,0,1,0,0,0,0,1,2'b10,16'h5000);
        chk_bit("R8", rd[14], 1'b1);
        chk_bit("R7", rd[12], 1'b0);
        // R7: clear everything
        apply(0,0,0,0,0,0,0,0,1,2'b11,16'hFFFF);
        chk_bit("R7", rd == 16'h00B0, 1'b1);

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] rw;
            rw = 16'($urandom);
            apply(($urandom % 8) == 0, $urandom % 2, $urandom % 2,
                  ($urandom % 10) == 0, ($urandom % 8) == 0, $urandom % 2,
                  ($urandom % 10) == 0, ($urandom % 10) == 0,
                  ($urandom % 4) == 0, 2'($urandom), rw);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule